// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit load/store processor. Each instruction runs over several clock cycles, and an external sequencer drives the control inputs for each cycle. One memory port carries both instruction fetches and data accesses. These two kinds of access use different cycles, and an address selector picks between the program counter and the staged ALU result. Values pass between steps through internal staging registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

The block contains a register file of 32 words. Register 0 is fixed at zero. The block also contains a five-function ALU with a zero flag and the selectors for operands, write destination, write-back data and next program counter. Memory reads are combinational: the word at the presented address must appear on the read-data input in the same cycle. A store is carried out by the sequencer. It raises the memory write strobe while the block presents the address and the store data.

Top module: `mc_datapath`

## Requirements
- R1: `addr_sel`=0 presents the program counter on `mem_addr`; `addr_sel`=1 presents the registered ALU result.
- R2: `instr` takes the value of `mem_rdata` on a clock edge when `ir_load` is 1, and otherwise keeps its value.
- R3: On every edge, the two operand registers load the register-file words indexed by instruction bits [25:21] and [20:16]. `mem_wdata` shows the second of these operand registers.
- R4: `opa_sel`=0 feeds the program counter to the first ALU input; `opa_sel`=1 feeds the first operand register.
- R5: `opb_sel` selects the second ALU input: 2'b00 the second operand register, 2'b01 the constant 4, 2'b10 the sign-extended instruction bits [15:0], 2'b11 that value shifted left by two.
- R6: `alu_func` codes: 3'b000 add, 3'b001 subtract (first minus second), 3'b010 AND, 3'b011 OR, 3'b100 signed set-less-than (result 1 or 0). Any other code adds. `alu_zero` is 1 exactly when the live ALU result is zero.
- R7: The ALU result register and the memory data register load on every edge: the first from the live ALU result, the second from `mem_rdata`.
- R8: During a register write, `dst_sel`=1 writes the register indexed by instruction bits [15:11], and `dst_sel`=0 the one indexed by bits [20:16].
- R9: `wb_sel`=0 writes the registered ALU result; `wb_sel`=1 writes the memory data register.
- R10: `pc_src` selects the next program counter: 2'b00 the live ALU result, 2'b01 the registered ALU result, 2'b10 the jump target {pc[31:28], instruction[25:0], 2'b00}. Code 2'b11 behaves as 2'b00.
- R11: The program counter updates only when `pc_write` is 1, or when `pc_write_cond` is 1 and `alu_zero` is 1.
- R12: Register 0 always reads as zero, and writes to it have no effect.
- R13: While `rst_n` is low, the program counter, every staging register and every register-file word are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_write | input | 1 | Unconditional program-counter update |
| pc_write_cond | input | 1 | Program-counter update when the ALU result is zero |
| addr_sel | input | 1 | Memory address source (0 program counter, 1 ALU result register) |
| ir_load | input | 1 | Instruction register load enable |
| reg_write | input | 1 | Register-file write enable |
| wb_sel | input | 1 | Write-back data source |
| dst_sel | input | 1 | Write-register field select |
| opa_sel | input | 1 | First ALU operand source |
| opb_sel | input | 2 | Second ALU operand source |
| alu_func | input | 3 | ALU function code |
| pc_src | input | 2 | Next program counter source |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| instr | output | 32 | Instruction register, for the sequencer to decode |
| pc | output | 32 | Program counter |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
On every cycle, the assertions check the register-transfer rules. These cover the instruction-register load and hold, the per-cycle loading of the operand, ALU-result and memory-data registers, the program counter holding when it is not enabled, and register 0 reading zero. The bench's instruction sequences are the only way to show that the selectors, ALU functions and write-back paths combine into correct results. Those sequences include loads of a negative word, each ALU function, a write aimed at register 0, a taken and an untaken branch, and a jump, and the stored results are compared against hand-computed words.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_AND = 3'b010,
    ALU_OR  = 3'b011,
    ALU_SLT = 3'b100
  } alu_op_e;

  function automatic word_t alu_eval(input alu_op_e op, input word_t x, input word_t y);
    word_t r;
    case (op)
      ALU_SUB: r = x - y;
      ALU_AND: r = x & y;
      ALU_OR:  r = x | y;
      ALU_SLT: r = ($signed(x) < $signed(y)) ? word_t'(1) : '0;
      default: r = x + y;
    endcase
    return r;
  endfunction

  function automatic word_t sext_imm(input word_t ins);
    return {{(DATA_W-IMM_W){ins[IMM_W-1]}}, ins[IMM_W-1:0]};
  endfunction

  function automatic word_t jump_target(input word_t cur_pc, input word_t ins);
    return {cur_pc[DATA_W-1:DATA_W-4], ins[DATA_W-7:0], 2'b00};
  endfunction
endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
(
  input  word_t      op_x,
  input  word_t      op_y,
  input  logic [2:0] func,
  output word_t      result,
  output logic       is_zero
);
  always_comb begin
    result  = alu_eval(alu_op_e'(func), op_x, op_y);
    is_zero = (result == '0);
  end
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
  import mcdp_pkg::*;
#(
  parameter int N_REGS = 32,
  localparam int IW = $clog2(N_REGS)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic [IW-1:0] rd_idx_a,
  input  logic [IW-1:0] rd_idx_b,
  output word_t   rd_a,
  output word_t   rd_b,
  input  logic    wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t   wr_data
);
  word_t regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_entry
    if (g == 0) begin : g_hardzero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               regs[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))       regs[g] <= wr_data;
      end
    end
  end

  assign rd_a = regs[rd_idx_a];
  assign rd_b = regs[rd_idx_b];

  assert_zero_reg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == '0) |-> (rd_a == '0));
  assert_zero_reg_b_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_b == '0) |-> (rd_b == '0));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcdp_pkg::*;
#(
  parameter int N_REGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_write,
  input  logic        pc_write_cond,
  input  logic        addr_sel,
  input  logic        ir_load,
  input  logic        reg_write,
  input  logic        wb_sel,
  input  logic        dst_sel,
  input  logic        opa_sel,
  input  logic [1:0]  opb_sel,
  input  logic [2:0]  alu_func,
  input  logic [1:0]  pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [31:0] instr,
  output logic [31:0] pc,
  output logic        alu_zero
);
  localparam int RIDX   = $clog2(N_REGS);
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  word_t pc_q, ir_q, mdr_q, a_q, b_q, alo_q;
  word_t rf_a, rf_b, opa, opb, alu_y, wr_data, pc_next, imm_ext;
  logic [RIDX-1:0] wr_idx;
  logic pc_en;

  mcdp_regfile #(.N_REGS(N_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx_a(ir_q[RS_LSB +: RIDX]), .rd_idx_b(ir_q[RT_LSB +: RIDX]),
    .rd_a(rf_a), .rd_b(rf_b),
    .wr_en(reg_write), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  mcdp_alu u_alu (
    .op_x(opa), .op_y(opb), .func(alu_func), .result(alu_y), .is_zero(alu_zero)
  );

  always_comb begin
    imm_ext = sext_imm(ir_q);
    opa     = opa_sel ? a_q : pc_q;
    case (opb_sel)
      2'b00:   opb = b_q;
      2'b01:   opb = word_t'(4);
      2'b10:   opb = imm_ext;
      default: opb = imm_ext << 2;
    endcase
    case (pc_src)
      2'b01:   pc_next = alo_q;
      2'b10:   pc_next = jump_target(pc_q, ir_q);
      default: pc_next = alu_y;
    endcase
    wr_idx  = dst_sel ? ir_q[RD_LSB +: RIDX] : ir_q[RT_LSB +: RIDX];
    wr_data = wb_sel ? mdr_q : alo_q;
    pc_en   = pc_write | (pc_write_cond & alu_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alo_q <= '0;
    end else begin
      mdr_q <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alo_q <= alu_y;
      if (ir_load) ir_q <= mem_rdata;
      if (pc_en)   pc_q <= pc_next;
    end
  end

  assign mem_addr  = addr_sel ? alo_q : pc_q;
  assign mem_wdata = b_q;
  assign instr     = ir_q;
  assign pc        = pc_q;

  assert_ir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (ir_q == $past(mem_rdata)));
  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir_q));
  assert_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_q == $past(rf_a) && b_q == $past(rf_b)));
  assert_staging_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alo_q == $past(alu_y) && mdr_q == $past(mem_rdata)));
  assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_write || (pc_write_cond && alu_zero)) |=> $stable(pc_q));
  assert_pc_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write |=> (pc_q == $past(pc_next)));
endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_write, pc_write_cond, addr_sel, ir_load, reg_write, wb_sel, dst_sel, opa_sel;
  logic [1:0] opb_sel, pc_src;
  logic [2:0] alu_func;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, instr, pc;
  logic alu_zero;
  logic mem_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit running = 0;

  logic [31:0] mem [64];

  // bench-side shadow of the architecture
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
  logic [31:0] m_rf [32];

  always #4 clk = ~clk;

  mc_datapath uut (
    .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .addr_sel(addr_sel), .ir_load(ir_load), .reg_write(reg_write), .wb_sel(wb_sel),
    .dst_sel(dst_sel), .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_func(alu_func),
    .pc_src(pc_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .instr(instr), .pc(pc), .alu_zero(alu_zero)
  );

  assign mem_rdata = mem[mem_addr[7:2]];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_calc(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    integer sx, sy;
    sx = x; sy = y;
    if (f == 3'd1) return x + (~y) + 32'd1;
    if (f == 3'd2) return x & y;
    if (f == 3'd3) return x | y;
    if (f == 3'd4) return (sx < sy) ? 32'd1 : 32'd0;
    return x + y;
  endfunction

  function automatic logic [31:0] ref_second();
    logic [31:0] ext;
    ext = m_ir[15] ? {16'hFFFF, m_ir[15:0]} : {16'h0000, m_ir[15:0]};
    if (opb_sel == 2'd0) return m_b;
    if (opb_sel == 2'd1) return 32'd4;
    if (opb_sel == 2'd2) return ext;
    return ext * 4;
  endfunction

  function automatic logic [31:0] ref_result();
    return ref_calc(alu_func, opa_sel ? m_a : m_pc, ref_second());
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  always @(posedge clk) begin
    logic [31:0] rd, res, adr;
    logic [4:0] dst;
    if (!rst_n) begin
      m_pc <= 0; m_ir <= 0; m_mdr <= 0; m_a <= 0; m_b <= 0; m_alo <= 0;
      for (int i = 0; i < 32; i++) m_rf[i] <= 0;
    end else begin
      adr = addr_sel ? m_alo : m_pc;
      rd  = mem[adr[7:2]];
      res = ref_result();
      m_mdr <= rd;
      m_a   <= m_rf[m_ir[25:21]];
      m_b   <= m_rf[m_ir[20:16]];
      m_alo <= res;
      if (ir_load) m_ir <= rd;
      if (reg_write) begin
        dst = dst_sel ? m_ir[15:11] : m_ir[20:16];
        if (dst != 0) m_rf[dst] <= wb_sel ? m_mdr : m_alo;
      end
      if (pc_write || (pc_write_cond && res == 0)) begin
        if (pc_src == 2'd1)      m_pc <= m_alo;
        else if (pc_src == 2'd2) m_pc <= {m_pc[31:28], m_ir[25:0], 2'b00};
        else                     m_pc <= res;
      end
    end
  end

  // per-cycle comparison against the shadow model
  always @(negedge clk) begin
    if (running) begin
      check("R1 address", mem_addr, addr_sel ? m_alo : m_pc);
      check("R2 instruction", instr, m_ir);
      check("R3 store data", mem_wdata, m_b);
      check("R6 zero flag", {31'd0, alu_zero}, {31'd0, ref_result() == 0});
      check("R11 program counter", pc, m_pc);
    end
  end

  task automatic idle();
    pc_write = 0; pc_write_cond = 0; addr_sel = 0; ir_load = 0; reg_write = 0;
    wb_sel = 0; dst_sel = 0; opa_sel = 0; opb_sel = 2'd0; alu_func = 3'd0; pc_src = 2'd0;
    mem_we = 0;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
    #1;
    idle();
  endtask

  task automatic fetch_decode();
    ir_load = 1; pc_write = 1; opb_sel = 2'd1;
    next_cycle();
    opb_sel = 2'd3;
    next_cycle();
  endtask

  task automatic run_load();
    fetch_decode();
    opa_sel = 1; opb_sel = 2'd2;
    next_cycle();
    addr_sel = 1;
    next_cycle();
    reg_write = 1; wb_sel = 1;
    next_cycle();
  endtask

  task automatic run_store();
    fetch_decode();
    opa_sel = 1; opb_sel = 2'd2;
    next_cycle();
    addr_sel = 1; mem_we = 1;
    next_cycle();
  endtask

  task automatic run_alu(input logic [2:0] f);
    fetch_decode();
    opa_sel = 1; alu_func = f;
    next_cycle();
    reg_write = 1; dst_sel = 1;
    next_cycle();
  endtask

  task automatic run_branch();
    fetch_decode();
    opa_sel = 1; alu_func = 3'd1; pc_write_cond = 1; pc_src = 2'd1;
    next_cycle();
  endtask

  task automatic run_jump();
    fetch_decode();
    pc_write = 1; pc_src = 2'd2;
    next_cycle();
  endtask

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[0]  = enc_i(35, 0, 1, 'h80);
    mem[1]  = enc_i(35, 0, 2, 'h84);
    mem[2]  = enc_r(1, 2, 3, 0);
    mem[3]  = enc_r(1, 2, 4, 1);
    mem[4]  = enc_r(1, 2, 5, 2);
    mem[5]  = enc_r(1, 2, 6, 3);
    mem[6]  = enc_r(2, 1, 7, 4);
    mem[7]  = enc_r(1, 1, 0, 0);
    mem[8]  = enc_i(43, 0, 3, 'h88);
    mem[9]  = enc_i(43, 0, 0, 'h8C);
    mem[10] = enc_i(4, 1, 1, 2);
    mem[11] = enc_i(43, 0, 4, 'h94);
    mem[13] = enc_i(4, 1, 2, 5);
    mem[14] = {6'd2, 26'd18};
    mem[18] = enc_i(43, 0, 7, 'h90);
    mem[19] = enc_i(43, 0, 5, 'h98);
    mem[20] = enc_i(43, 0, 6, 'h9C);
    mem[21] = enc_i(43, 0, 4, 'hA0);
    mem[32] = 32'd7;
    mem[33] = 32'hFFFF_FFF6;
    mem[35] = 32'h0000_DEAD;
    mem[37] = 32'h0000_5555;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset pc", pc, 32'd0);
    check("R13 reset instr", instr, 32'd0);
    check("R13 reset store data", mem_wdata, 32'd0);
    check("R13 reset address", mem_addr, 32'd0);
    rst_n = 1;
    #1;
    running = 1;
    run_load();                 // r1 = 7
    run_load();                 // r2 = -10 (sign of loaded word kept)
    run_alu(3'd0);              // r3 = -3
    run_alu(3'd1);              // r4 = 17
    run_alu(3'd2);              // r5 = 6
    run_alu(3'd3);              // r6 = 0xFFFFFFF7
    run_alu(3'd4);              // r7 = 1
    run_alu(3'd0);              // write aimed at r0
    run_store();                // mem[34] = r3
    run_store();                // mem[35] = r0
    run_branch();               // taken, skips to 52
    check("R10 branch target", pc, 32'd52);
    run_branch();               // not taken
    check("R11 untaken branch", pc, 32'd56);
    run_jump();
    check("R10 jump target", pc, 32'd72);
    run_store();                // mem[36] = r7
    run_store();                // mem[38] = r5
    run_store();                // mem[39] = r6
    run_store();                // mem[40] = r4
    running = 0;
    check("R4 R5 R6 add of loaded words", mem[34], 32'hFFFF_FFFD);
    check("R12 register zero stays zero", mem[35], 32'd0);
    check("R6 signed set-less-than", mem[36], 32'd1);
    check("R11 skipped store left word", mem[37], 32'h0000_5555);
    check("R8 R6 and result", mem[38], 32'd6);
    check("R9 R6 or result", mem[39], 32'hFFFF_FFF7);
    check("R7 subtract via staged operands", mem[40], 32'd17);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule